// File: doc/BRIEF.md
# ATM Cell Transmit Port (8-bit, cell-level handshake)

This block sits between an internal byte-stream producer and a PHY device, and moves fixed 53-octet ATM cells onto an 8-bit transmit bus that runs on the system clock. Each cell goes out as five header octets followed by 48 payload octets. An active-low enable marks the octets carrying cell data, and a start-of-cell strobe marks the first header octet. The data bus is held at zero whenever enable is inactive.

The producer side is a valid/ready stream with a start-of-cell flag. The block stores whole cells internally, with a parameterised number of cell slots, and puts a cell on the line only after all 53 octets of it are held. Back-pressure works as follows. The ready output drops when every slot holds a complete cell. A byte transfers on a clock where valid and ready are both high. A byte flagged as start-of-cell always opens a fresh cell in the slot being filled, discarding any partial cell there. A byte without the flag that arrives when no cell is open is accepted and dropped.

The PHY signals that it has room through a cell-available input. When the port is idle, this input is sampled on every clock. While a cell is being sent, it is sampled once, on the clock that carries the 44th payload octet, and that sample decides whether the next stored cell follows with no gap. Changes on the input at any other octet of a cell, the first header octet included, have no effect.

Top module: `utx_cell_port`

## Requirements
- R1: Every complete cell accepted from the source appears on `tx_data` as 53 consecutive octets with `tx_en_n` low, in the byte order and cell order of acceptance.
- R2: `tx_soc` is high on exactly the first of the 53 octets of each cell and low on the other 52.
- R3: Whenever `tx_en_n` is high, `tx_data` is 8'h00 and `tx_soc` is low.
- R4: From idle, a cell starts on the clock after one where `phy_clav` is high and at least one complete cell is stored. A partially received cell, or `phy_clav` low, keeps `tx_en_n` high.
- R5: During a cell, only the `phy_clav` value at payload octet 44 (octet index 48, counting H1 as 0) decides the next cell. If that value is high and another complete cell is stored, the next cell's H1 follows the current cell's last octet directly, so successive start strobes are 53 clocks apart. This holds even when `phy_clav` is low at H1 and at every other octet.
- R6: If `phy_clav` is low at payload octet 44, `tx_en_n` goes high for at least one clock after the cell's last octet. The next cell then starts through the idle rule of R4, so start strobes are at least 54 clocks apart.
- R7: A started cell is always sent in full. `tx_en_n` stays low for all 53 octets whatever `phy_clav` does.
- R8: `s_ready` is low exactly when all `NUM_SLOTS` slots hold complete cells. A start-of-cell byte discards any partial cell being filled. A non-start byte arriving with no cell open is discarded.
- R9: While `rst_n` is low at a clock edge, the port returns to idle: `tx_en_n` high, `tx_soc` low, `tx_data` zero, no cells stored, and `s_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the transmit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_data | input | 8 | Source octet |
| s_sop | input | 1 | Source octet is the first of a cell |
| s_valid | input | 1 | Source octet valid |
| s_ready | output | 1 | Port can accept an octet |
| phy_clav | input | 1 | PHY can accept another cell |
| tx_en_n | output | 1 | Active-low transmit enable |
| tx_soc | output | 1 | Start-of-cell strobe, high on H1 |
| tx_data | output | 8 | Transmit octet, zero when enable is high |

## Verification
If the octet counter or the slot pointers are wrong, the very next cell shows it: a misplaced start strobe, enable rising before the 53rd octet, or an octet that does not match what the scoreboard queued. If the window sampler is wrong, the spacing of start strobes on the following cell shows it (53 against 54 or more clocks), so stimulus places `phy_clav` edges on chosen octet indices. If the stored-cell count is wrong, it shows at the source port as `s_ready` at the wrong time, or on the line as a cell that starts early, starts late, or never starts.

// File: rtl/utx_pkg.sv
package utx_pkg;
  localparam int unsigned CELL_OCTETS = 53;  // 5 header + 48 payload
  localparam int unsigned OCT_W       = 6;
  localparam int unsigned CLAV_IDX    = 48;  // payload octet 44
  typedef logic [7:0] octet_t;
endpackage

// File: rtl/utx_cell_store.sv
module utx_cell_store
  import utx_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 2,
  localparam int unsigned CNT_W    = $clog2(NUM_SLOTS + 1),
  localparam int unsigned SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int unsigned TOTAL    = NUM_SLOTS * CELL_OCTETS,
  localparam int unsigned AW       = $clog2(TOTAL)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  octet_t           s_data,
  input  logic             s_sop,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [OCT_W-1:0] rd_idx,
  input  logic             release_cell,
  output octet_t           rd_data,
  output logic [CNT_W-1:0] full_cnt
);
  localparam logic [OCT_W-1:0] LAST_IDX = OCT_W'(CELL_OCTETS - 1);
  localparam logic [CNT_W-1:0] MAX_CNT  = CNT_W'(NUM_SLOTS);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

  octet_t mem [TOTAL];
  logic [SLOT_W-1:0] wr_slot, rd_slot;
  logic [OCT_W-1:0]  wr_idx;
  logic              accept, wr_en, cell_done;
  logic [OCT_W-1:0]  wr_pos;
  logic [AW-1:0]     wr_addr, rd_addr;

  assign s_ready   = (full_cnt != MAX_CNT);
  assign accept    = s_valid && s_ready;
  assign wr_en     = accept && (s_sop || wr_idx != '0);
  assign wr_pos    = s_sop ? '0 : wr_idx;
  assign cell_done = wr_en && !s_sop && (wr_idx == LAST_IDX);
  assign wr_addr   = AW'(int'(wr_slot) * CELL_OCTETS + int'(wr_pos));
  assign rd_addr   = AW'(int'(rd_slot) * CELL_OCTETS + int'(rd_idx));
  assign rd_data   = mem[rd_addr];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= s_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_slot  <= '0;
      rd_slot  <= '0;
      wr_idx   <= '0;
      full_cnt <= '0;
    end else begin
      if (accept) begin
        if (s_sop)                 wr_idx <= OCT_W'(1);
        else if (wr_idx == LAST_IDX) wr_idx <= '0;
        else if (wr_idx != '0)     wr_idx <= wr_idx + 1'b1;
      end
      if (cell_done)
        wr_slot <= (wr_slot == LAST_SLOT) ? '0 : wr_slot + 1'b1;
      if (release_cell)
        rd_slot <= (rd_slot == LAST_SLOT) ? '0 : rd_slot + 1'b1;
      case ({cell_done, release_cell})
        2'b10:   full_cnt <= full_cnt + 1'b1;
        2'b01:   full_cnt <= full_cnt - 1'b1;
        default: full_cnt <= full_cnt;
      endcase
    end
  end

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    full_cnt <= MAX_CNT);
  assert_release_has_cell_R4: assert property (@(posedge clk) disable iff (!rst_n)
    release_cell |-> full_cnt != '0);
  assert_full_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (full_cnt == MAX_CNT && !release_cell) |=> !s_ready);
endmodule

// File: rtl/utx_clav_window.sv
module utx_clav_window
  import utx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sending,
  input  logic [OCT_W-1:0] oct,
  input  logic             phy_clav,
  output logic             go_next
);
  localparam logic [OCT_W-1:0] SAMPLE_AT = OCT_W'(CLAV_IDX);
  logic sample_now;
  assign sample_now = sending && (oct == SAMPLE_AT);

  always_ff @(posedge clk) begin
    if (!rst_n)          go_next <= 1'b0;
    else if (sample_now) go_next <= phy_clav;
  end

  assert_window_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_now |=> $stable(go_next));
endmodule

// File: rtl/utx_tx_sequencer.sv
module utx_tx_sequencer
  import utx_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 2,
  localparam int unsigned CNT_W    = $clog2(NUM_SLOTS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             phy_clav,
  input  logic [CNT_W-1:0] full_cnt,
  input  logic             go_next,
  input  octet_t           rd_data,
  output logic             sending,
  output logic [OCT_W-1:0] oct,
  output logic             release_cell,
  output logic             tx_en_n,
  output logic             tx_soc,
  output octet_t           tx_data
);
  localparam logic [OCT_W-1:0] LAST_IDX = OCT_W'(CELL_OCTETS - 1);

  logic last_oct, start_idle, chain;
  assign last_oct     = sending && (oct == LAST_IDX);
  assign start_idle   = !sending && phy_clav && (full_cnt != '0);
  assign chain        = last_oct && go_next && (full_cnt >= CNT_W'(2));
  assign release_cell = last_oct;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sending <= 1'b0;
      oct     <= '0;
    end else if (start_idle) begin
      sending <= 1'b1;
      oct     <= '0;
    end else if (last_oct) begin
      sending <= chain;
      oct     <= '0;
    end else if (sending) begin
      oct     <= oct + 1'b1;
    end
  end

  assign tx_en_n = !sending;
  assign tx_soc  = sending && (oct == '0);
  assign tx_data = sending ? rd_data : 8'h00;

  assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en_n |-> (tx_data == 8'h00 && !tx_soc));
  assert_cell_completes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sending && oct != LAST_IDX) |=> (sending && oct == $past(oct) + 1'b1));
  assert_start_needs_cell_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sending) |-> ($past(phy_clav) && $past(full_cnt) != '0));
  assert_chain_needs_go_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (last_oct && !go_next) |=> !sending);
endmodule

// File: rtl/utx_cell_port.sv
module utx_cell_port
  import utx_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] s_data,
  input  logic       s_sop,
  input  logic       s_valid,
  output logic       s_ready,
  input  logic       phy_clav,
  output logic       tx_en_n,
  output logic       tx_soc,
  output logic [7:0] tx_data
);
  localparam int unsigned CNT_W = $clog2(NUM_SLOTS + 1);

  logic [CNT_W-1:0] full_cnt;
  logic [OCT_W-1:0] oct;
  logic             sending, release_cell, go_next;
  octet_t           rd_data;

  utx_cell_store #(.NUM_SLOTS(NUM_SLOTS)) u_store (
    .clk, .rst_n, .s_data, .s_sop, .s_valid, .s_ready,
    .rd_idx(oct), .release_cell, .rd_data, .full_cnt
  );

  utx_clav_window u_window (
    .clk, .rst_n, .sending, .oct, .phy_clav, .go_next
  );

  utx_tx_sequencer #(.NUM_SLOTS(NUM_SLOTS)) u_seq (
    .clk, .rst_n, .phy_clav, .full_cnt, .go_next, .rd_data,
    .sending, .oct, .release_cell, .tx_en_n, .tx_soc, .tx_data
  );
endmodule

// File: tb/utx_cell_port_tb.sv
module utx_cell_port_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] s_data = 8'h00;
  logic       s_sop = 1'b0, s_valid = 1'b0, phy_clav = 1'b0;
  logic       s_ready, tx_en_n, tx_soc;
  logic [7:0] tx_data;

  int checks = 0, errors = 0, cyc = 0, pos = 0;
  logic [7:0] exp_q[$];

  always #2 clk = ~clk;  // 250 MHz
  always @(posedge clk) cyc <= cyc + 1;

  utx_cell_port u_dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // scoreboard monitor (R1, R2, R3, R7)
  always @(negedge clk) begin
    if (rst_n) begin
      if (!tx_en_n) begin
        if (exp_q.size() == 0) chk(0, "R1 unexpected octet", tx_data, -1);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(tx_data == e, "R1 octet", tx_data, e);
        end
        chk(tx_soc == (pos == 0), "R2 strobe", tx_soc, pos == 0);
        pos = (pos == 52) ? 0 : pos + 1;
      end else begin
        chk(pos == 0, "R7 cell cut short", pos, 0);
        chk(tx_data == 8'h00 && !tx_soc, "R3 idle bus", tx_data, 0);
      end
    end
  end

  task automatic push_byte(input logic [7:0] d, input logic sop);
    @(negedge clk);
    while (!s_ready) @(negedge clk);
    s_valid = 1'b1; s_data = d; s_sop = sop;
    @(posedge clk);
  endtask

  task automatic idle_src();
    @(negedge clk);
    s_valid = 1'b0; s_sop = 1'b0;
  endtask

  task automatic send_cell(input logic [7:0] base, input int upto);
    for (int i = 0; i < upto; i++) push_byte(base + 8'(i), i == 0);
    if (upto == 53) for (int i = 0; i < 53; i++) exp_q.push_back(base + 8'(i));
  endtask

  task automatic finish_cell(input logic [7:0] base, input int from);
    for (int i = from; i < 53; i++) push_byte(base + 8'(i), 1'b0);
    for (int i = 0; i < 53; i++) exp_q.push_back(base + 8'(i));
  endtask

  task automatic wait_soc(output int t);
    @(negedge clk);
    while (!tx_soc) @(negedge clk);
    t = cyc;
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    finish_run();
  end

  initial begin
    int t1, t2;
    repeat (3) @(negedge clk);
    chk(tx_en_n && !tx_soc && tx_data == 0 && s_ready, "R9 reset state", tx_en_n, 1);
    rst_n = 1'b1;

    // R4: partial cell must not start
    phy_clav = 1'b1;
    send_cell(8'h10, 52);
    idle_src();
    repeat (20) @(negedge clk);
    chk(tx_en_n, "R4 partial cell held", tx_en_n, 1);
    finish_cell(8'h10, 52);
    idle_src();
    repeat (70) @(negedge clk);

    // R4 clav low holds; R8 ready drops when full; R5 back-to-back
    phy_clav = 1'b0;
    send_cell(8'h40, 53);
    send_cell(8'h80, 53);
    idle_src();
    repeat (20) @(negedge clk);
    chk(tx_en_n, "R4 clav low holds", tx_en_n, 1);
    chk(!s_ready, "R8 ready low when full", s_ready, 0);
    phy_clav = 1'b1;
    wait_soc(t1);
    wait_soc(t2);
    chk(t2 - t1 == 53, "R5 back-to-back spacing", t2 - t1, 53);
    repeat (60) @(negedge clk);

    // R5: clav low at H1 and everywhere except P44 still chains
    phy_clav = 1'b0;
    send_cell(8'hA0, 53);
    send_cell(8'h05, 53);
    idle_src();
    phy_clav = 1'b1;
    wait_soc(t1);
    phy_clav = 1'b0;
    repeat (48) @(negedge clk);
    phy_clav = 1'b1;
    @(negedge clk);
    phy_clav = 1'b0;
    wait_soc(t2);
    chk(t2 - t1 == 53, "R5 only P44 sample counts", t2 - t1, 53);
    phy_clav = 1'b1;
    repeat (60) @(negedge clk);

    // R6: clav low only at P44 inserts a gap
    phy_clav = 1'b0;
    send_cell(8'h33, 53);
    send_cell(8'hC7, 53);
    idle_src();
    phy_clav = 1'b1;
    wait_soc(t1);
    repeat (48) @(negedge clk);
    phy_clav = 1'b0;
    @(negedge clk);
    phy_clav = 1'b1;
    repeat (4) @(negedge clk);
    chk(tx_en_n, "R6 enable high after cell", tx_en_n, 1);
    wait_soc(t2);
    chk(t2 - t1 == 54, "R6 gap spacing", t2 - t1, 54);
    repeat (60) @(negedge clk);

    // R8: abandoned partial cell and stray bytes are discarded
    send_cell(8'hE0, 10);
    send_cell(8'h21, 53);
    push_byte(8'h99, 1'b0);
    push_byte(8'h98, 1'b0);
    send_cell(8'h61, 53);
    idle_src();
    repeat (130) @(negedge clk);
    chk(exp_q.size() == 0, "R8 discarded bytes never sent", exp_q.size(), 0);

    // R7: clav drop mid-cell does not cut the cell
    send_cell(8'h71, 53);
    idle_src();
    wait_soc(t1);
    repeat (10) @(negedge clk);
    phy_clav = 1'b0;
    repeat (60) @(negedge clk);
    chk(exp_q.size() == 0 && pos == 0, "R7 full cell sent", exp_q.size(), 0);

    // R9: reset mid-stream returns to idle
    phy_clav = 1'b0;
    send_cell(8'h55, 53);
    idle_src();
    rst_n = 1'b0;
    exp_q.delete();
    @(negedge clk);
    chk(tx_en_n && s_ready && tx_data == 0, "R9 reset clears", tx_en_n, 1);
    rst_n = 1'b1;
    phy_clav = 1'b1;
    repeat (10) @(negedge clk);
    chk(tx_en_n, "R9 no cell stored after reset", tx_en_n, 1);
    finish_run();
  end
endmodule